// File: doc/BRIEF.md
# Byte-Level I2C Master Transmitter with Status Handshake

This block is an I2C master that sends bytes under software control. Software sets up a transfer through three registers. The control register requests START, repeated START or STOP and clears the event flag. The data register holds the next byte to send, either an address or data. An 8-bit status code reports what happened last on the bus. Each bus step ends with the event flag raised and a status code that describes the outcome. The engine then holds the bus until software clears the flag, and that clearing write also names the next action.

The engine drives SCL and SDA as open-drain outputs: an output that is high pulls the line low. It reads the real line levels back on two inputs. One SCL period lasts four phases, and each phase is `QTR_CYCLES` clock cycles long. The engine starts a transfer only when the bus has been idle long enough. If another driver forces SDA low while the engine is releasing it, the engine stops driving both lines.

Top module: `i2c_mtx_engine`

## Requirements
- R1: After reset the flag is 0, the status reads F8h and neither line is driven low.
- R2: A START request with `reg_sel`=0 and bits [0]=enable=1, [1]=start=1, [2]=stop=0, [3]=flag=0 begins the START only after SCL and SDA have both been high for at least one SCL period (4*`QTR_CYCLES` cycles). When the START completes, the flag is set, the status reads 08h and SCL is held low.
- R3: While the flag is set, neither line output changes and the status holds.
- R4: After an address byte, the status reads 18h for ACK and 20h for NACK when bit 0 of the byte is 0 (write). It reads 40h for ACK and 48h for NACK when bit 0 is 1 (read).
- R5: After a data byte, the status reads 28h for ACK and 30h for NACK.
- R6: A data-register write (`reg_sel`=1) made while the flag is 0 is discarded, and the byte held before that write is the one sent.
- R7: Bytes go out MSB first. Within a byte, SDA changes only while SCL is low. The acknowledge is read during the ninth SCL high.
- R8: A control write with start=1 while the engine owns the bus produces a repeated START with status 10h and no STOP in between.
- R9: A control write with stop=1 while the engine owns the bus produces a STOP. The flag stays 0, the status becomes F8h and both lines end released.
- R10: If SDA reads low during an SCL high in which the engine releases SDA for a 1 bit, the engine releases both lines, sets the flag and reports 38h.
- R11: A control write with enable=0 abandons any transfer, releases both lines, clears the flag and sets the status to F8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects data |
| reg_wdata | input | 8 | Write data |
| flag | output | 1 | Event flag; the bus is suspended while it is high |
| status | output | 8 | Status code of the last event |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The assertions assume that SCL follows the engine's own drive. No slave stretches the clock, so a released SCL reads high within the same phase. The bench makes its slave model drive SDA only while SCL is low, except for the arbitration scenario. In that scenario it pulls SDA low only after SCL has risen. Register writes are single-cycle strobes. Writes to the data register with the flag low are made on purpose to exercise the discard rule.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;

    localparam logic       SEL_CTRL = 1'b0;
    localparam logic       SEL_DATA = 1'b1;
    localparam int         CB_EN    = 0;
    localparam int         CB_STA   = 1;
    localparam int         CB_STO   = 2;
    localparam int         CB_FLAG  = 3;

    localparam logic [7:0] SC_START   = 8'h08;
    localparam logic [7:0] SC_RSTART  = 8'h10;
    localparam logic [7:0] SC_AW_ACK  = 8'h18;
    localparam logic [7:0] SC_AW_NACK = 8'h20;
    localparam logic [7:0] SC_D_ACK   = 8'h28;
    localparam logic [7:0] SC_D_NACK  = 8'h30;
    localparam logic [7:0] SC_LOST    = 8'h38;
    localparam logic [7:0] SC_AR_ACK  = 8'h40;
    localparam logic [7:0] SC_AR_NACK = 8'h48;
    localparam logic [7:0] SC_IDLE    = 8'hF8;

    typedef enum logic [2:0] {
        FS_IDLE, FS_WAITFREE, FS_START, FS_HOLD, FS_BYTE, FS_RSTART, FS_STOP
    } fsm_e;

    typedef struct packed {
        fsm_e       fsm;
        logic [1:0] ph;
        logic [3:0] bitn;
        logic [7:0] shreg;
        logic [7:0] data;
        logic [7:0] stat;
        logic       flag;
        logic       scl_lo;
        logic       sda_lo;
        logic       owned;
        logic       addr_next;
        logic       rd_mode;
        logic       nack;
    } eng_t;

endpackage

// File: rtl/i2c_mtx_tick.sv
module i2c_mtx_tick #(
    parameter int QTR_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [W-1:0] LAST = W'(QTR_CYCLES - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/i2c_mtx_busfree.sv
module i2c_mtx_busfree #(
    parameter int PERIOD = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic free
);
    localparam int W = $clog2(PERIOD + 1);
    localparam logic [W-1:0] LIM = W'(PERIOD);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!(scl_in && sda_in)) cnt_d = '0;
        else if (cnt_q != LIM)   cnt_d = cnt_q + 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign free = (cnt_q == LIM);
endmodule

// File: rtl/i2c_mtx_engine.sv
module i2c_mtx_engine
    import i2c_mtx_pkg::*;
#(
    parameter int QTR_CYCLES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic       flag,
    output logic [7:0] status,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       scl_in,
    input  logic       sda_in
);
    localparam int PERIOD = 4 * QTR_CYCLES;

    eng_t q, n;
    logic tick, bus_free, run;
    logic ctl_wr, dat_wr, clr_evt;

    assign run = (q.fsm == FS_START) || (q.fsm == FS_BYTE) ||
                 (q.fsm == FS_RSTART) || (q.fsm == FS_STOP);

    i2c_mtx_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    i2c_mtx_busfree #(.PERIOD(PERIOD)) u_free (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .free(bus_free)
    );

    assign ctl_wr  = reg_we && (reg_sel == SEL_CTRL);
    assign dat_wr  = reg_we && (reg_sel == SEL_DATA);
    assign clr_evt = ctl_wr && !reg_wdata[CB_FLAG];

    always_comb begin
        n = q;
        if (dat_wr && q.flag) n.data = reg_wdata;
        if (ctl_wr && !reg_wdata[CB_EN]) begin
            n.fsm = FS_IDLE;  n.flag = 1'b0;  n.stat = SC_IDLE;
            n.scl_lo = 1'b0;  n.sda_lo = 1'b0; n.owned = 1'b0;
            n.ph = '0;
        end else begin
            case (q.fsm)
                FS_IDLE, FS_HOLD: begin
                    if (clr_evt && (q.flag || q.fsm == FS_IDLE)) begin
                        n.flag = 1'b0;
                        n.ph   = '0;
                        if (reg_wdata[CB_STA]) begin
                            n.fsm = q.owned ? FS_RSTART : FS_WAITFREE;
                        end else if (reg_wdata[CB_STO] || (q.owned && q.rd_mode)) begin
                            n.fsm = q.owned ? FS_STOP : FS_IDLE;
                            if (!q.owned) n.stat = SC_IDLE;
                        end else if (q.owned) begin
                            n.fsm   = FS_BYTE;
                            n.bitn  = '0;
                            n.shreg = q.data;
                        end else begin
                            n.fsm  = FS_IDLE;
                            n.stat = SC_IDLE;
                        end
                    end
                end
                FS_WAITFREE: begin
                    if (bus_free) begin
                        n.fsm = FS_START;
                        n.ph  = '0;
                    end
                end
                FS_START: if (tick) begin
                    case (q.ph)
                        2'd0:    begin n.sda_lo = 1'b1; n.ph = 2'd1; end
                        2'd1:    begin n.scl_lo = 1'b1; n.ph = 2'd2; end
                        default: begin
                            n.flag = 1'b1; n.stat = SC_START; n.owned = 1'b1;
                            n.addr_next = 1'b1; n.rd_mode = 1'b0; n.fsm = FS_HOLD;
                        end
                    endcase
                end
                FS_RSTART: if (tick) begin
                    case (q.ph)
                        2'd0: begin n.sda_lo = 1'b0; n.ph = 2'd1; end
                        2'd1: begin n.scl_lo = 1'b0; n.ph = 2'd2; end
                        2'd2: begin n.sda_lo = 1'b1; n.ph = 2'd3; end
                        default: begin
                            n.scl_lo = 1'b1; n.flag = 1'b1; n.stat = SC_RSTART;
                            n.addr_next = 1'b1; n.rd_mode = 1'b0; n.fsm = FS_HOLD;
                        end
                    endcase
                end
                FS_BYTE: if (tick) begin
                    case (q.ph)
                        2'd0: begin
                            n.sda_lo = (q.bitn == 4'd8) ? 1'b0 : ~q.shreg[7];
                            n.ph     = 2'd1;
                        end
                        2'd1: begin n.scl_lo = 1'b0; n.ph = 2'd2; end
                        2'd2: begin
                            n.ph = 2'd3;
                            if (q.bitn == 4'd8) begin
                                n.nack = sda_in;
                            end else if (!q.sda_lo && !sda_in) begin
                                n.scl_lo = 1'b0; n.sda_lo = 1'b0; n.owned = 1'b0;
                                n.flag = 1'b1;   n.stat = SC_LOST; n.fsm = FS_HOLD;
                            end else begin
                                n.shreg = {q.shreg[6:0], 1'b0};
                            end
                        end
                        default: begin
                            n.scl_lo = 1'b1;
                            n.ph     = 2'd0;
                            if (q.bitn == 4'd8) begin
                                n.flag = 1'b1;
                                n.fsm  = FS_HOLD;
                                n.addr_next = 1'b0;
                                if (q.addr_next) begin
                                    n.rd_mode = q.data[0];
                                    if (q.data[0]) n.stat = q.nack ? SC_AR_NACK : SC_AR_ACK;
                                    else           n.stat = q.nack ? SC_AW_NACK : SC_AW_ACK;
                                end else begin
                                    n.stat = q.nack ? SC_D_NACK : SC_D_ACK;
                                end
                            end else begin
                                n.bitn = q.bitn + 4'd1;
                            end
                        end
                    endcase
                end
                FS_STOP: if (tick) begin
                    case (q.ph)
                        2'd0:    begin n.sda_lo = 1'b1; n.ph = 2'd1; end
                        2'd1:    begin n.scl_lo = 1'b0; n.ph = 2'd2; end
                        default: begin
                            n.sda_lo = 1'b0; n.owned = 1'b0; n.stat = SC_IDLE;
                            n.fsm = FS_IDLE; n.ph = '0;
                        end
                    endcase
                end
                default: n.fsm = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.fsm  <= FS_IDLE;
            q.stat <= SC_IDLE;
        end else begin
            q <= n;
        end
    end

    assign flag          = q.flag;
    assign status        = q.stat;
    assign scl_drive_low = q.scl_lo;
    assign sda_drive_low = q.sda_lo;

    // R3
    hold_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !ctl_wr) |=> (scl_drive_low == $past(scl_drive_low)) &&
                                (sda_drive_low == $past(sda_drive_low)) &&
                                (status == $past(status)));

    // R6
    discard_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !q.flag) |=> (q.data == $past(q.data)));

    // R7
    sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fsm == FS_BYTE && $past(q.fsm) == FS_BYTE && !q.scl_lo && !$past(q.scl_lo))
        |-> (q.sda_lo == $past(q.sda_lo)));

    // R2
    start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fsm == FS_START && $past(q.fsm) == FS_WAITFREE) |-> $past(bus_free));

    // R10
    lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && q.stat == SC_LOST) |-> (!scl_drive_low && !sda_drive_low));

    // R9
    flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.flag |-> (status != SC_IDLE));
endmodule

// File: tb/i2c_mtx_engine_test.sv
module i2c_mtx_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       flag;
    logic [7:0] status;
    logic       scl_drive_low, sda_drive_low;
    logic       ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic       slv_sda_low = 1'b0;
    logic       slave_ack = 1'b1;
    logic       scl_w, sda_w;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    assign scl_w = !(scl_drive_low || ext_scl_low);
    assign sda_w = !(sda_drive_low || slv_sda_low || ext_sda_low);

    always #5 clk = ~clk;

    i2c_mtx_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .flag(flag), .status(status),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .scl_in(scl_w), .sda_in(sda_w)
    );

    // slave model: records bytes, acknowledges per slave_ack
    logic [7:0] last_byte = 8'h00;
    logic [7:0] sh = 8'h00;
    int  scnt = 0;
    bit  armed = 1'b0;
    logic pscl = 1'b1, psda = 1'b1;
    always @(scl_w or sda_w) begin
        if (pscl && scl_w && psda && !sda_w) begin
            scnt = 0; armed = 1'b0; slv_sda_low = 1'b0;
        end else if (!pscl && scl_w) begin
            if (armed && scnt < 8) sh = {sh[6:0], sda_w};
        end else if (pscl && !scl_w) begin
            if (!armed) armed = 1'b1;
            else begin
                scnt = scnt + 1;
                if (scnt == 8) begin last_byte = sh; slv_sda_low = slave_ack; end
                else if (scnt == 9) begin slv_sda_low = 1'b0; scnt = 0; end
            end
        end
        pscl = scl_w; psda = sda_w;
    end

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ctl(input bit en, input bit sta, input bit sto);
        wr(1'b0, {4'b0, 1'b0, sto, sta, en});
    endtask

    task automatic wait_flag(input string req);
        int k = 0;
        while (!flag && k < 3000) begin @(negedge clk); k++; end
        check(flag, req, flag, 1);
    endtask

    task automatic do_start(input string req);
        ctl(1, 1, 0);
        wait_flag(req);
        check(status == 8'h08, req, status, 8'h08);
    endtask

    task automatic send(input logic [7:0] b, input logic [7:0] exp_st, input string req);
        wr(1'b1, b);
        ctl(1, 0, 0);
        wait_flag(req);
        check(status == exp_st, req, status, exp_st);
        check(last_byte == b, "R7 byte MSB first", last_byte, b);
    endtask

    task automatic do_stop;
        int k = 0;
        ctl(1, 0, 1);
        while (status != 8'hF8 && k < 3000) begin @(negedge clk); k++; end
        repeat (5) @(negedge clk);
        check(status == 8'hF8 && !flag, "R9 stop status", status, 8'hF8);
        check(scl_w && sda_w, "R9 lines released", {scl_w, sda_w}, 2'b11);
    endtask

    task automatic t_reset;
        check(!flag, "R1 flag", flag, 0);
        check(status == 8'hF8, "R1 status", status, 8'hF8);
        check(!scl_drive_low && !sda_drive_low, "R1 lines", {scl_drive_low, sda_drive_low}, 0);
    endtask

    task automatic t_busfree;
        int k = 0;
        ext_scl_low = 1'b1;
        ctl(1, 1, 0);
        repeat (60) @(negedge clk);
        check(!flag && !sda_drive_low, "R2 no start on busy bus", sda_drive_low, 0);
        ext_scl_low = 1'b0;
        while (!sda_drive_low && k < 500) begin @(negedge clk); k++; end
        check(k >= 20 && k < 60, "R2 free wait", k, 20);
        wait_flag("R2 start flag");
        check(status == 8'h08, "R2 start status", status, 8'h08);
        check(!scl_w, "R2 scl held", scl_w, 0);
    endtask

    task automatic t_addr_hold;
        send(8'hA6, 8'h18, "R4 addr write ack");
        repeat (40) @(negedge clk);
        check(flag && status == 8'h18 && !scl_w, "R3 suspended", status, 8'h18);
    endtask

    task automatic t_discard;
        wr(1'b1, 8'h3C);
        ctl(1, 0, 0);
        wr(1'b1, 8'h99);
        wait_flag("R6 flag");
        check(status == 8'h28, "R5 data ack", status, 8'h28);
        check(last_byte == 8'h3C, "R6 current byte", last_byte, 8'h3C);
        ctl(1, 0, 0);
        wait_flag("R6 flag 2");
        check(last_byte == 8'h3C, "R6 discarded write", last_byte, 8'h3C);
    endtask

    task automatic t_data_nack;
        slave_ack = 1'b0;
        send(8'h55, 8'h30, "R5 data nack");
        slave_ack = 1'b1;
    endtask

    task automatic t_rstart_read;
        ctl(1, 1, 0);
        wait_flag("R8 flag");
        check(status == 8'h10, "R8 rstart status", status, 8'h10);
        check(!scl_w, "R8 bus kept", scl_w, 0);
        send(8'hA7, 8'h40, "R4 addr read ack");
        do_stop();
    endtask

    task automatic t_addr_nack;
        do_start("R2 start again");
        slave_ack = 1'b0;
        send(8'h40, 8'h20, "R4 addr write nack");
        slave_ack = 1'b1;
        do_stop();
    endtask

    task automatic t_arb;
        int k = 0;
        do_start("R2 start arb");
        wr(1'b1, 8'hA0);
        ctl(1, 0, 0);
        while (!scl_w && k < 500) begin @(negedge clk); k++; end
        ext_sda_low = 1'b1;
        wait_flag("R10 flag");
        check(status == 8'h38, "R10 lost status", status, 8'h38);
        check(!scl_drive_low && !sda_drive_low, "R10 released",
              {scl_drive_low, sda_drive_low}, 0);
        ext_sda_low = 1'b0;
        ctl(1, 0, 0);
        repeat (3) @(negedge clk);
        check(!flag && status == 8'hF8, "R10 back to idle", status, 8'hF8);
    endtask

    task automatic t_disable;
        repeat (30) @(negedge clk);
        do_start("R11 start");
        wr(1'b0, 8'h00);
        @(negedge clk);
        check(!flag && status == 8'hF8, "R11 status", status, 8'hF8);
        check(!scl_drive_low && !sda_drive_low, "R11 lines", {scl_drive_low, sda_drive_low}, 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busfree();
        t_addr_hold();
        t_discard();
        t_data_nack();
        t_rstart_read();
        t_addr_nack();
        t_arb();
        t_disable();
        repeat (10) @(negedge clk);
        report();
    end
endmodule